// File: doc/BRIEF.md
# I2C Role and Direction Controller

This block owns the two control bits that decide whether an I2C controller acts as bus master or slave, and whether it sends or receives. The CPU reads and writes these bits. The bus engine also reports three kinds of event to the block: lost arbitration, a received address byte with its R/W bit, and whether a byte transfer is in progress. The block combines both sources into one 2-bit mode that it drives to the rest of the controller.

Hardware events take priority over software. Once hardware has forced a bit, the CPU must read the register before a write of the opposite value is accepted. A software change of direction made while a byte is moving is held back and applied when the byte finishes.

Each bit is guarded by a lock state machine with three states: `LK_FREE`, `LK_FORCED` and `LK_ARMED`. Its transitions are:
- **force**: any state goes to `LK_FORCED` on that bit's hardware event.
- **arm**: `LK_FORCED` goes to `LK_ARMED` on a CPU read.
- **release**: `LK_ARMED` goes to `LK_FREE` when a write of the opposite value is accepted.

The direction bit also has a defer state machine with two states, `DF_IDLE` and `DF_HOLD`. Its transitions are:
- **hold**: `DF_IDLE` goes to `DF_HOLD` when a write is accepted while the transfer is busy.
- **refresh**: `DF_HOLD` stays in `DF_HOLD` on a further accepted write, which replaces the held value.
- **drain**: `DF_HOLD` goes to `DF_IDLE` in the first cycle that busy is low, and the held value is applied.
- **cancel**: either state goes to `DF_IDLE` on a direction hardware event.

Top module: `i2c_mode_ctl`

## Requirements
- R1: `mode[1]` is the role (1 = master) and `mode[0]` is the direction (1 = transmit). The four codes are 00 slave receive, 01 slave transmit, 10 master receive and 11 master transmit.
- R2: After reset, `mode` is 00 and both locks are free.
- R3: When no lock blocks it and no transfer is busy, a CPU write loads `cpu_wdata` into `mode` at the next clock edge.
- R4: `arb_lost` while `mode[1]`=1 clears both bits at the next edge and forces both locks. `arb_lost` while `mode[1]`=0 has no effect.
- R5: `addr_seen` while `mode`=00 loads `addr_rw` into `mode[0]` and forces the direction lock. In any other mode, `addr_seen` is ignored.
- R6: While a bit is forced and has not been read, a write of the opposite value to that bit is ignored.
- R7: A CPU read while a bit is forced arms that bit. The next opposite-value write is then accepted and frees the lock, so later writes behave as in R3.
- R8: An accepted direction write made while `xfer_busy`=1 leaves `mode[0]` unchanged until the first edge at which `xfer_busy` is 0, when the written value is applied. Role writes are never deferred.
- R9: When several direction writes land during one busy transfer, only the last one is applied.
- R10: When any hardware event lands in the same cycle as a CPU write, the write is discarded for both bits.
- R11: A direction hardware event cancels any pending deferred direction write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | CPU write strobe, one cycle |
| cpu_wdata | input | 2 | Write data as {role, direction} |
| cpu_rd | input | 1 | CPU read strobe; the read data is `mode` |
| arb_lost | input | 1 | Bus engine: arbitration lost |
| addr_seen | input | 1 | Bus engine: first frame after a start received |
| addr_rw | input | 1 | R/W bit of that frame |
| xfer_busy | input | 1 | High while a byte transfer is active |
| mode | output | 2 | Current {role, direction} |

## Verification
The assertions assume that `arb_lost` and `addr_seen` are single-cycle pulses. They also assume that `xfer_busy` is a level that falls only at the end of a byte. The direction-hold property assumes that the direction bit never moves during busy cycles unless a hardware event occurs. The stimulus keeps within these rules: it raises each event for exactly one vector, and it holds busy high across every vector of a deferred sequence until a single vector drops it. Events are injected only where the block's mode gives them meaning, or deliberately where the block must ignore them.

// File: rtl/i2c_mode_pkg.sv
package i2c_mode_pkg;
    localparam int MODE_W   = 2;
    localparam int ROLE_IDX = 1;
    localparam int DIR_IDX  = 0;

    typedef enum logic [1:0] {
        LK_FREE   = 2'd0,
        LK_FORCED = 2'd1,
        LK_ARMED  = 2'd2
    } lock_st_t;

    typedef enum logic {
        DF_IDLE = 1'b0,
        DF_HOLD = 1'b1
    } defer_st_t;
endpackage

// File: rtl/mode_lock.sv
module mode_lock
    import i2c_mode_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hw_evt,
    input  logic veto,
    input  logic cpu_rd,
    input  logic wr_req,
    input  logic wr_val,
    input  logic cur_val,
    output logic wr_ok
);
    lock_st_t st_q, st_d;
    logic     blocked;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= LK_FREE;
        else        st_q <= st_d;
    end

    always_comb begin
        blocked = (st_q == LK_FORCED) && (wr_val != cur_val);
        wr_ok   = wr_req && !veto && !blocked;
        st_d    = st_q;
        if (hw_evt) begin
            st_d = LK_FORCED;
        end else begin
            unique case (st_q)
                LK_FREE:   st_d = LK_FREE;
                LK_FORCED: if (cpu_rd) st_d = LK_ARMED;
                LK_ARMED:  if (wr_ok && (wr_val != cur_val)) st_d = LK_FREE;
                default:   st_d = LK_FREE;
            endcase
        end
    end

    // R6
    no_unread_rewrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == LK_FORCED && wr_req && wr_val != cur_val && !hw_evt)
            |=> (cur_val == $past(cur_val)));
endmodule

// File: rtl/dir_defer.sv
module dir_defer
    import i2c_mode_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic wr_val,
    input  logic busy,
    input  logic cancel,
    output logic apply,
    output logic apply_val
);
    defer_st_t st_q, st_d;
    logic      pend_q, pend_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= DF_IDLE;
            pend_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            pend_q <= pend_d;
        end
    end

    always_comb begin
        st_d      = st_q;
        pend_d    = pend_q;
        apply     = 1'b0;
        apply_val = pend_q;
        if (cancel) begin
            st_d = DF_IDLE;
        end else begin
            unique case (st_q)
                DF_IDLE: begin
                    if (accept) begin
                        if (busy) begin
                            st_d   = DF_HOLD;
                            pend_d = wr_val;
                        end else begin
                            apply     = 1'b1;
                            apply_val = wr_val;
                        end
                    end
                end
                DF_HOLD: begin
                    if (accept) pend_d = wr_val;
                    if (!busy) begin
                        apply     = 1'b1;
                        apply_val = accept ? wr_val : pend_q;
                        st_d      = DF_IDLE;
                    end
                end
                default: st_d = DF_IDLE;
            endcase
        end
    end

    // R8
    hold_no_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cancel) |-> !apply);
endmodule

// File: rtl/i2c_mode_ctl.sv
module i2c_mode_ctl
    import i2c_mode_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic [MODE_W-1:0] cpu_wdata,
    input  logic              cpu_rd,
    input  logic              arb_lost,
    input  logic              addr_seen,
    input  logic              addr_rw,
    input  logic              xfer_busy,
    output logic [MODE_W-1:0] mode
);
    logic [MODE_W-1:0] mode_q;
    logic [MODE_W-1:0] hw_evt, hw_val, wr_ok;
    logic              master_lost, slave_addr, veto;
    logic              dir_apply, dir_apply_val;

    assign master_lost = arb_lost && mode_q[ROLE_IDX];
    assign slave_addr  = addr_seen && (mode_q == 2'b00);
    assign veto        = |hw_evt;

    always_comb begin
        hw_evt           = '0;
        hw_val           = '0;
        hw_evt[ROLE_IDX] = master_lost;
        hw_evt[DIR_IDX]  = master_lost || slave_addr;
        hw_val[DIR_IDX]  = master_lost ? 1'b0 : addr_rw;
    end

    for (genvar g = 0; g < MODE_W; g++) begin : g_lock
        mode_lock u_lock (
            .clk    (clk),
            .rst_n  (rst_n),
            .hw_evt (hw_evt[g]),
            .veto   (veto),
            .cpu_rd (cpu_rd),
            .wr_req (cpu_wr),
            .wr_val (cpu_wdata[g]),
            .cur_val(mode_q[g]),
            .wr_ok  (wr_ok[g])
        );
    end

    dir_defer u_defer (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (wr_ok[DIR_IDX]),
        .wr_val   (cpu_wdata[DIR_IDX]),
        .busy     (xfer_busy),
        .cancel   (hw_evt[DIR_IDX]),
        .apply    (dir_apply),
        .apply_val(dir_apply_val)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else begin
            if (hw_evt[ROLE_IDX])     mode_q[ROLE_IDX] <= hw_val[ROLE_IDX];
            else if (wr_ok[ROLE_IDX]) mode_q[ROLE_IDX] <= cpu_wdata[ROLE_IDX];
            if (hw_evt[DIR_IDX])      mode_q[DIR_IDX]  <= hw_val[DIR_IDX];
            else if (dir_apply)       mode_q[DIR_IDX]  <= dir_apply_val;
        end
    end

    always_comb mode = mode_q;

    // R4
    arb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_lost && mode[1]) |=> (mode == 2'b00));
    // R5
    slave_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_seen && mode == 2'b00) |=> (mode[0] == $past(addr_rw)));
    // R8
    busy_dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_busy && !arb_lost && !(addr_seen && mode == 2'b00)) |=> $stable(mode[0]));
    // R10
    hw_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_seen && mode == 2'b00 && cpu_wr) |=> (mode[1] == 1'b0));
endmodule

// File: tb/i2c_mode_ctl_bench.sv
module i2c_mode_ctl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_wr = 1'b0, cpu_rd = 1'b0;
    logic [1:0] cpu_wdata = 2'b00;
    logic       arb_lost = 1'b0, addr_seen = 1'b0, addr_rw = 1'b0, xfer_busy = 1'b0;
    logic [1:0] mode;
    int         n_vec = 0, n_bad = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    i2c_mode_ctl u_i2c_mode_ctl (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .arb_lost(arb_lost), .addr_seen(addr_seen),
        .addr_rw(addr_rw), .xfer_busy(xfer_busy), .mode(mode)
    );

    // {req[3:0], wr, wdata[1:0], rd, arb, addr, rw, busy, expected mode[1:0]}
    // Mode codes (R1): 00 SR, 01 ST, 10 MR, 11 MT.
    localparam int NV = 33;
    localparam logic [13:0] VEC [NV] = '{
        14'b0011_1_11_0_0_0_0_0_11, // R3 plain write
        14'b0100_0_00_0_1_0_0_0_00, // R4 arbitration loss as master
        14'b0110_1_11_0_0_0_0_0_00, // R6 rewrite without read
        14'b0111_0_00_1_0_0_0_0_00, // R7 read arms
        14'b0111_1_11_0_0_0_0_0_11, // R7 accepted
        14'b0111_1_01_0_0_0_0_0_01, // R7 lock released
        14'b0011_1_00_0_0_0_0_0_00, // R3
        14'b0101_0_00_0_0_1_1_0_01, // R5 slave address, R/W=1
        14'b0110_1_00_0_0_0_0_0_01, // R6 direction blocked
        14'b0111_0_00_1_0_0_0_0_01, // R7
        14'b0111_1_00_0_0_0_0_0_00, // R7
        14'b0001_1_10_0_0_0_0_0_10, // R1 master receive code
        14'b0101_0_00_0_0_1_1_0_10, // R5 address ignored outside 00
        14'b0011_1_01_0_0_0_0_0_01, // R3
        14'b0100_0_00_0_1_0_0_0_01, // R4 arbitration loss as slave ignored
        14'b0011_1_00_0_0_0_0_0_00, // R3
        14'b1000_1_11_0_0_0_0_1_10, // R8 role now, direction held
        14'b1000_0_00_0_0_0_0_1_10, // R8 still busy
        14'b1000_0_00_0_0_0_0_0_11, // R8 applied at end
        14'b1001_1_10_0_0_0_0_1_11, // R9
        14'b1001_1_11_0_0_0_0_1_11, // R9
        14'b1001_1_10_0_0_0_0_1_11, // R9 last value 0
        14'b1001_0_00_0_0_0_0_0_10, // R9 last one wins
        14'b0011_1_00_0_0_0_0_0_00, // R3
        14'b1010_1_10_0_0_1_1_0_01, // R10 event beats write
        14'b0111_0_00_1_0_0_0_0_01, // R7
        14'b0111_1_10_0_0_0_0_0_10, // R7
        14'b1000_1_11_0_0_0_0_1_10, // R8 pending direction 1
        14'b1011_0_00_0_1_0_0_1_00, // R11 event cancels pending
        14'b1011_0_00_0_0_0_0_0_00, // R11 nothing applied at end
        14'b0110_1_11_0_0_0_0_0_00, // R6 both forced
        14'b0111_0_00_1_0_0_0_0_00, // R7
        14'b0111_1_11_0_0_0_0_0_11  // R7
    };

    task automatic check(input logic [1:0] exp, input int req);
        n_vec++;
        if (mode !== exp) begin
            n_bad++;
            $display("FAIL R%0d: mode=%b expected=%b", req, mode, exp);
        end
    endtask

    task automatic drive(input logic [13:0] v);
        cpu_wr    = v[9];
        cpu_wdata = v[8:7];
        cpu_rd    = v[6];
        arb_lost  = v[5];
        addr_seen = v[4];
        addr_rw   = v[3];
        xfer_busy = v[2];
        @(negedge clk);
        check(v[1:0], int'(v[13:10]));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(2'b00, 2); // R2 reset state
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) drive(VEC[i]);
        // R2: a reset mid-run returns to 00 and frees the locks
        drive(14'b0100_0_00_0_1_0_0_0_00);
        rst_n = 1'b0;
        drive(14'b0010_0_00_0_0_0_0_0_00);
        rst_n = 1'b1;
        drive(14'b0010_1_11_0_0_0_0_0_11); // R2 locks free after reset
        drive(14'b0001_1_01_0_0_0_0_0_01); // R1 slave transmit code
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule